// File: doc/BRIEF.md
# Serial Control-Word Loader

This block takes configuration for a frequency synthesizer over a three-wire serial port: a serial clock, a serial data line and a load strobe. All three lines are synchronised into the system clock domain. One data bit enters a 19-bit shift register on each rising edge of the serial clock. When the load strobe rises, the register is copied into one of two holding registers. The bit shifted in last picks which one.

One holding register keeps the reference divide value and four mode bits: prescaler modulus select, phase-detector polarity, monitor output select and charge-pump current select. The other keeps the swallow count and the main counter value. A divide value below 3 is rejected. In that case the holding register keeps its old contents and a sticky error flag goes high. The divider logic reads the latched fields straight from the outputs.

Top module: `ctrl_word_loader`

## Requirements
- R1: After reset, reference divide = 3, main count = 3, swallow count = 0, all four mode bits = 0 and the error flag = 0.
- R2: One data bit is taken on each rising serial-clock edge, most significant bit first. Register bit 0 holds the last bit received, which is the destination select.
- R3: With select bit = 1, bits 14:1 give the reference divide value (bit 1 is its LSB). The range 3 to 16383 is accepted.
- R4: With select bit = 1, the mode bits are taken from fixed positions: bit 15 is the prescaler select, bit 16 the phase polarity, bit 17 the monitor select and bit 18 the charge-pump current select.
- R5: With select bit = 0, bits 7:1 give the swallow count (0 to 127) and bits 18:8 give the main count (3 to 2047).
- R6: A load updates only the holding register named by the select bit. The other register keeps its value.
- R7: A reference word carrying a divide value below 3 leaves the reference register and the mode bits unchanged and sets the error flag.
- R8: A counter word carrying a main count below 3 leaves both the swallow and main counts unchanged and sets the error flag.
- R9: The error flag stays high through later valid loads and is cleared only by reset.
- R10: Each high pulse of the load strobe causes exactly one load. Words shifted in while the strobe stays high have no effect until the strobe rises again.
- R11: When more than 19 bits arrive before a load, only the last 19 are used.
- R12: A load strobe rising before system clock edge k shows on the outputs after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe |
| ref_div_o | output | 14 | Latched reference divide value |
| pre_sel_o | output | 1 | Prescaler modulus select |
| phase_pol_o | output | 1 | Phase-detector polarity |
| mon_sel_o | output | 1 | Monitor output select |
| cp_hi_o | output | 1 | Charge-pump high-current select |
| swallow_o | output | 7 | Latched swallow count |
| main_div_o | output | 11 | Latched main count |
| bad_div_o | output | 1 | Sticky illegal-divide flag |

## Verification
The bench covers the following corner cases, with the failure each one would expose:
- Divide values at the edges of their ranges: 3, 16383, 127 and 2047. An off-by-one field slice would show here as a shifted or truncated value.
- Illegal divide values of 2 and 0. A design that latched these anyway would leave an unusable divider setting; one that cleared the flag on the next good word would hide the fault.
- An overlong frame. A design that counted bits instead of keeping a sliding window would decode the leading junk bits.
- A load strobe held high while a new word shifts in. A level-sensitive load would copy that word before the next strobe edge.

// File: rtl/loader_pkg.sv
package loader_pkg;
  localparam int WORD_W  = 19;
  localparam int REF_W   = 14;
  localparam int SWL_W   = 7;
  localparam int MAIN_W  = 11;
  localparam int MIN_DIV = 3;

  typedef struct packed {
    logic             cp_hi;
    logic             mon_sel;
    logic             phase_pol;
    logic             pre_sel;
    logic [REF_W-1:0] ref_div;
  } ref_cfg_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main_div;
    logic [SWL_W-1:0]  swallow;
  } cnt_cfg_t;
endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0][STAGES:0] pipe_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= '0;
      else         pipe_q[i] <= {pipe_q[i][STAGES-1:0], async_i[i]};
    end
    assign lvl_o[i]  = pipe_q[i][STAGES-1];
    assign rise_o[i] = pipe_q[i][STAGES-1] & ~pipe_q[i][STAGES];

    // R10
    single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/shift_word.sv
module shift_word #(
  parameter int W = loader_pkg::WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
  end

  // R2
  newest_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> word_o[0] == $past(bit_i));
  // R11
  slide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> word_o[W-1:1] == $past(word_o[W-2:0]));
endmodule

// File: rtl/word_latch.sv
module word_latch
  import loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output ref_cfg_t          ref_o,
  output cnt_cfg_t          cnt_o,
  output logic              bad_o
);
  ref_cfg_t ref_w;
  cnt_cfg_t cnt_w;
  logic     sel_ref, ref_ok, cnt_ok;

  // bit 0 is the destination select, payload above it
  assign sel_ref = word_i[0];
  assign ref_w   = ref_cfg_t'(word_i[WORD_W-1:1]);
  assign cnt_w   = cnt_cfg_t'(word_i[WORD_W-1:1]);
  assign ref_ok  = ref_w.ref_div  >= REF_W'(MIN_DIV);
  assign cnt_ok  = cnt_w.main_div >= MAIN_W'(MIN_DIV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o <= '{ref_div: REF_W'(MIN_DIV), default: 1'b0};
      cnt_o <= '{main_div: MAIN_W'(MIN_DIV), swallow: '0};
      bad_o <= 1'b0;
    end else if (load_i) begin
      if (sel_ref) begin
        if (ref_ok) ref_o <= ref_w;
        else        bad_o <= 1'b1;
      end else begin
        if (cnt_ok) cnt_o <= cnt_w;
        else        bad_o <= 1'b1;
      end
    end
  end

  // R7
  ref_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o.ref_div >= REF_W'(MIN_DIV));
  // R8
  main_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o.main_div >= MAIN_W'(MIN_DIV));
  // R9
  bad_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |=> bad_o);
  // R6
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && sel_ref) |=> $stable(ref_o));
  // R6
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && !sel_ref) |=> $stable(cnt_o));
endmodule

// File: rtl/ctrl_word_loader.sv
module ctrl_word_loader
  import loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_le_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic              pre_sel_o,
  output logic              phase_pol_o,
  output logic              mon_sel_o,
  output logic              cp_hi_o,
  output logic [SWL_W-1:0]  swallow_o,
  output logic [MAIN_W-1:0] main_div_o,
  output logic              bad_div_o
);
  localparam int NLINES = 3;

  logic [NLINES-1:0] lvl, rise;
  logic [WORD_W-1:0] word;
  ref_cfg_t          ref_q;
  cnt_cfg_t          cnt_q;

  // line order: 0 = serial clock, 1 = data, 2 = load strobe
  serial_sync #(.N(NLINES), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({ser_le_i, ser_data_i, ser_clk_i}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  shift_word #(.W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(rise[0]),
    .bit_i  (lvl[1]),
    .word_o (word)
  );

  word_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(rise[2]),
    .word_i(word),
    .ref_o (ref_q),
    .cnt_o (cnt_q),
    .bad_o (bad_div_o)
  );

  assign ref_div_o   = ref_q.ref_div;
  assign pre_sel_o   = ref_q.pre_sel;
  assign phase_pol_o = ref_q.phase_pol;
  assign mon_sel_o   = ref_q.mon_sel;
  assign cp_hi_o     = ref_q.cp_hi;
  assign swallow_o   = cnt_q.swallow;
  assign main_div_o  = cnt_q.main_div;
endmodule

// File: tb/sim_ctrl_word_loader.sv
module sim_ctrl_word_loader;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
  logic [13:0] ref_div;
  logic        pre_sel, phase_pol, mon_sel, cp_hi, bad;
  logic [6:0]  swl;
  logic [10:0] main_div;

  int compared = 0, mismatched = 0, cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  ctrl_word_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdat), .ser_le_i(sle),
    .ref_div_o(ref_div), .pre_sel_o(pre_sel), .phase_pol_o(phase_pol),
    .mon_sel_o(mon_sel), .cp_hi_o(cp_hi), .swallow_o(swl), .main_div_o(main_div),
    .bad_div_o(bad)
  );

  // behavioural reference model
  logic [2:0] hist[$];          // {le,data,clk} per sampled edge, newest first
  bit   [18:0] m_word;
  int m_ref, m_main, m_swl;
  bit m_pre, m_pol, m_mon, m_cp, m_bad;

  task automatic model_reset();
    hist = '{3'b000, 3'b000, 3'b000};
    m_word = '0; m_ref = 3; m_main = 3; m_swl = 0;
    m_pre = 0; m_pol = 0; m_mon = 0; m_cp = 0; m_bad = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      logic [2:0] cur, old;
      cur = hist[1]; old = hist[2];
      if (cur[2] && !old[2]) begin
        if (m_word[0]) begin
          if (int'(m_word[14:1]) < 3) m_bad = 1;
          else begin
            m_ref = int'(m_word[14:1]); m_pre = m_word[15]; m_pol = m_word[16];
            m_mon = m_word[17]; m_cp = m_word[18];
          end
        end else begin
          if (int'(m_word[18:8]) < 3) m_bad = 1;
          else begin m_swl = int'(m_word[7:1]); m_main = int'(m_word[18:8]); end
        end
      end
      if (cur[0] && !old[0]) m_word = {m_word[17:0], cur[1]};
      hist.push_front({sle, sdat, sclk});
      void'(hist.pop_back());
    end
  end

  // R12: per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (int'(ref_div) != m_ref || int'(main_div) != m_main || int'(swl) != m_swl ||
          pre_sel != m_pre || phase_pol != m_pol || mon_sel != m_mon ||
          cp_hi != m_cp || bad != m_bad) begin
        mismatched++;
        $display("FAIL R12 cycle %0d: got ref=%0d main=%0d swl=%0d modes=%b%b%b%b bad=%b exp ref=%0d main=%0d swl=%0d modes=%b%b%b%b bad=%b",
          cycles, ref_div, main_div, swl, cp_hi, mon_sel, phase_pol, pre_sel, bad,
          m_ref, m_main, m_swl, m_cp, m_mon, m_pol, m_pre, m_bad);
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i]; wait_clk(3);
      sclk = 1'b1; wait_clk(3);
      sclk = 1'b0;
    end
    wait_clk(3);
  endtask

  task automatic strobe();
    sle = 1'b1; wait_clk(4); sle = 1'b0; wait_clk(6);
  endtask

  function automatic logic [18:0] ref_word(int r, bit ps, bit pol, bit mon, bit cp);
    return {cp, mon, pol, ps, 14'(r), 1'b1};
  endfunction

  function automatic logic [18:0] cnt_word(int s, int m);
    return {11'(m), 7'(s), 1'b0};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset values
    chk("R1 ref", ref_div, 3); chk("R1 main", main_div, 3); chk("R1 swl", swl, 0);
    chk("R1 modes", {cp_hi, mon_sel, phase_pol, pre_sel}, 0); chk("R1 bad", bad, 0);

    // R2 R3 R4 R6: reference word
    send_bits(32'(ref_word(1000, 1, 0, 1, 0)), 19); strobe();
    chk("R3 ref", ref_div, 1000);
    chk("R4 modes", {cp_hi, mon_sel, phase_pol, pre_sel}, 4'b0101);
    chk("R6 main kept", main_div, 3);

    // R5 R6: counter word
    send_bits(32'(cnt_word(5, 1234)), 19); strobe();
    chk("R5 swl", swl, 5); chk("R5 main", main_div, 1234);
    chk("R6 ref kept", ref_div, 1000);

    // R3 R4 upper bound, inverted mode pattern
    send_bits(32'(ref_word(16383, 0, 1, 0, 1)), 19); strobe();
    chk("R3 ref max", ref_div, 16383);
    chk("R4 modes b", {cp_hi, mon_sel, phase_pol, pre_sel}, 4'b1010);

    // R7 illegal reference
    send_bits(32'(ref_word(2, 1, 1, 1, 1)), 19); strobe();
    chk("R7 ref kept", ref_div, 16383);
    chk("R7 modes kept", {cp_hi, mon_sel, phase_pol, pre_sel}, 4'b1010);
    chk("R7 bad", bad, 1);

    // R8 illegal main
    send_bits(32'(cnt_word(9, 0)), 19); strobe();
    chk("R8 swl kept", swl, 5); chk("R8 main kept", main_div, 1234);

    // R9 flag survives a valid load; R5 bounds
    send_bits(32'(cnt_word(127, 3)), 19); strobe();
    chk("R5 swl max", swl, 127); chk("R5 main min", main_div, 3);
    chk("R9 bad sticky", bad, 1);

    // R11 overlong frame: 6 junk bits then the word
    send_bits({7'b0, 6'b111011, cnt_word(42, 2047)}, 25); strobe();
    chk("R11 swl", swl, 42); chk("R11 main", main_div, 2047);

    // R10 strobe held high while a new word shifts in
    send_bits(32'(ref_word(77, 1, 1, 0, 0)), 19);
    sle = 1'b1; wait_clk(4);
    chk("R10 first load", ref_div, 77);
    send_bits(32'(ref_word(500, 0, 0, 1, 1)), 19);
    chk("R10 no reload", ref_div, 77);
    chk("R10 modes held", {cp_hi, mon_sel, phase_pol, pre_sel}, 4'b0011);
    sle = 1'b0; wait_clk(4);
    strobe();
    chk("R10 next pulse", ref_div, 500);

    // R1 R9 reset clears all
    rst_n = 1'b0; wait_clk(2); rst_n = 1'b1; wait_clk(2);
    chk("R9 cleared", bad, 0); chk("R1 ref again", ref_div, 3);
    chk("R1 main again", main_div, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule